// File: doc/BRIEF.md
# Sector Error Correction Applier

This block sits after a four-error-per-sector error locator. It writes the locator's verdict into a 512-byte sector buffer. A start pulse hands it five things: a 4-bit correction state code, an error count, two address words, two value words and the ten stored parity bytes. Each address word carries two 10-bit error locations and each value word carries two 8-bit flip masks. If the job calls for correction, the block walks the error list and XORs each mask into the addressed buffer byte. It does this with a read-modify-write through the buffer's only port. It then raises `done` for one cycle and reports a 2-bit verdict and the number of bytes it changed.

The host loads and unloads the sector through a plain byte port whenever the block is idle. The buffer byte index of an error is 519 minus its reported location, so locations 8 to 519 map to bytes 511 down to 0. Any other location lands in the parity bytes and is passed over. A parity field of all 0xFF bytes marks an erased page, and such a page is never touched.

The controller has five states:
- IDLE: waits for start.
- CLASSIFY: sorts the job.
- FETCH: picks the next entry and issues the buffer read when the entry is in range.
- MODIFY: writes back the XOR-ed byte.
- FINISH: publishes the verdict.

It moves between them on six transitions:
- start-accept: IDLE to CLASSIFY.
- no-work: CLASSIFY to FINISH.
- begin-walk: CLASSIFY to FETCH.
- hit: FETCH to MODIFY.
- skip: FETCH stays in FETCH, or goes to FINISH when the entry is the last.
- next: MODIFY goes to FETCH, or to FINISH when the entry is the last.

FINISH always returns to IDLE.

Top module: `sector_fix_apply`

## Requirements
- R1: After reset `fix_status` is 00 (clean), `fix_count` is 0, and `done` and `busy` are low.
- R2: If all ten bytes of `stored_parity` are 0xFF at start, the job ends clean (00) with count 0 and the buffer unchanged, whatever the state code. One byte that is not 0xFF is enough to cancel this.
- R3: State code 0 ends clean (00) with count 0 and the buffer unchanged.
- R4: State code 1, or any code from 4 to 15, ends failed (10) with count 0 and the buffer unchanged.
- R5: State codes 2 and 3 walk `err_count` entries, with counts above 4 treated as 4. Entries 0 and 1 come from `err_addr_lo`/`err_val_lo`, and entries 2 and 3 come from `err_addr_hi`/`err_val_hi`. In each word the even entry sits in bits [9:0] (address) or [7:0] (value), and the odd entry sits in bits [25:16] or [23:16]. All other bits are ignored.
- R6: For an entry with location A, the byte at index 519−A is replaced by itself XOR the entry's value.
- R7: An entry whose index 519−A is not in 0..511 changes no byte and is not counted.
- R8: After a job with code 2 or 3, the verdict is 01 (corrected) and `fix_count` equals the number of bytes changed. `busy` is high from the cycle after start until the verdict. `done` is high for exactly one cycle, and the verdict holds until the next job ends.
- R9: A host write with `busy` low stores `host_wdata` at `host_addr`. Read data for `host_addr` appears on `host_rdata` one cycle later. Host writes while `busy` is high are dropped.
- R10: A start pulse while `busy` is high is ignored: the running job finishes with its own inputs and no second `done` follows.
- R11: Two entries that point at the same byte both take effect, one after the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 9 | Host byte index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Buffer read data, one cycle after the address |
| start | input | 1 | Begin a correction job |
| corr_state | input | 4 | Correction state code from the locator |
| err_count | input | 3 | Number of reported errors |
| err_addr_lo | input | 32 | Locations of entries 0 and 1 |
| err_val_lo | input | 32 | Masks of entries 0 and 1 |
| err_addr_hi | input | 32 | Locations of entries 2 and 3 |
| err_val_hi | input | 32 | Masks of entries 2 and 3 |
| stored_parity | input | 80 | The ten parity bytes read from the page |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| fix_status | output | 2 | 00 clean, 01 corrected, 10 failed |
| fix_count | output | 3 | Bytes changed by the last job |

## Verification
The bench targets these corner cases:
- Locations 8 and 519, the two ends of the valid window. A design with an off-by-one index would flip a neighbouring byte, or drop one of them.
- Locations 0 to 7 and above 519, which must fall in the parity bytes. A design that wraps the subtraction would corrupt a data byte instead.
- Two entries that hit the same byte, which must cancel the bytes' bits in turn. A design that reads stale data would keep only one of the two.
- A parity field that differs from all-0xFF in its top byte only, which must not count as erased.
- An error count of 7 carried with junk in the unused word bits. A design that did not clamp the count or mask the fields would fix too much.
- A host write and a second start issued mid-job, both of which must be dropped. A design that let either through would corrupt the sector or rerun the job.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    localparam int SECTOR_BYTES = 512;
    localparam int PARITY_BYTES = 10;
    localparam int MAX_ERRS     = 4;
    localparam int LOC_W        = 10;
    localparam int MASK_W       = 8;
    localparam int CODE_W       = 4;
    localparam int WORD_W       = 32;
    localparam int LANE_SHIFT   = 16;

    typedef enum logic [1:0] {
        FIX_CLEAN  = 2'b00,
        FIX_DONE   = 2'b01,
        FIX_FAILED = 2'b10
    } fix_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLASSIFY,
        S_FETCH,
        S_MODIFY,
        S_FINISH
    } ctl_state_e;

endpackage

// File: rtl/parity_erase_check.sv
module parity_erase_check #(
    parameter int NBYTES = ecc_fix_pkg::PARITY_BYTES
) (
    input  logic [NBYTES*8-1:0] parity,
    output logic                erased
);

    logic [NBYTES-1:0] byte_full;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign byte_full[i] = &parity[i*8 +: 8];
    end

    assign erased = &byte_full;

endmodule

// File: rtl/err_entry_pick.sv
module err_entry_pick #(
    parameter int SECTOR_BYTES = ecc_fix_pkg::SECTOR_BYTES,
    parameter int MAX_ERRS     = ecc_fix_pkg::MAX_ERRS,
    parameter int LOC_W        = ecc_fix_pkg::LOC_W,
    parameter int MASK_W       = ecc_fix_pkg::MASK_W,
    parameter int WORD_W       = ecc_fix_pkg::WORD_W,
    parameter int LANE_SHIFT   = ecc_fix_pkg::LANE_SHIFT,
    localparam int NWORDS      = MAX_ERRS / 2,
    localparam int SEL_W       = $clog2(MAX_ERRS),
    localparam int IDX_W       = $clog2(SECTOR_BYTES)
) (
    input  logic [NWORDS-1:0][WORD_W-1:0] loc_words,
    input  logic [NWORDS-1:0][WORD_W-1:0] mask_words,
    input  logic [SEL_W-1:0]              sel,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx,
    output logic [MASK_W-1:0]             mask
);

    localparam int DW = LOC_W + 2;
    localparam logic [DW-1:0] BASE = DW'(SECTOR_BYTES + 7);
    localparam logic [DW-1:0] LIMIT = DW'(SECTOR_BYTES);

    logic [WORD_W-1:0] lw, mw;
    logic [LOC_W-1:0]  loc;
    logic [DW-1:0]     loc_ext, diff;

    always_comb begin
        lw      = loc_words[sel[SEL_W-1:1]];
        mw      = mask_words[sel[SEL_W-1:1]];
        loc     = sel[0] ? lw[LANE_SHIFT +: LOC_W] : lw[0 +: LOC_W];
        mask    = sel[0] ? mw[LANE_SHIFT +: MASK_W] : mw[0 +: MASK_W];
        loc_ext = DW'(loc);
        diff    = BASE - loc_ext;
        hit     = (loc_ext <= BASE) && (diff < LIMIT);
        idx     = diff[IDX_W-1:0];
    end

    logic unused_bits;
    assign unused_bits = ^{lw, mw, diff};

endmodule

// File: rtl/sector_ram.sv
module sector_ram #(
    parameter int DEPTH = ecc_fix_pkg::SECTOR_BYTES,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
    import ecc_fix_pkg::*;
#(
    parameter int MAX_ERRS  = ecc_fix_pkg::MAX_ERRS,
    parameter int CODE_W    = ecc_fix_pkg::CODE_W,
    parameter int MASK_W    = ecc_fix_pkg::MASK_W,
    parameter int IDX_W     = 9,
    localparam int CNT_W    = $clog2(MAX_ERRS + 1),
    localparam int SEL_W    = $clog2(MAX_ERRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              erased_i,
    input  logic              ent_hit,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [MASK_W-1:0] ent_mask,
    input  logic [MASK_W-1:0] rd_data,
    output logic              take_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [IDX_W-1:0]  eng_addr,
    output logic              eng_we,
    output logic [MASK_W-1:0] eng_wdata,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [CNT_W-1:0]  fixcnt_o
);

    localparam logic [CNT_W-1:0]  MAX_CNT   = CNT_W'(MAX_ERRS);
    localparam logic [CODE_W-1:0] CODE_NONE = CODE_W'(0);
    localparam logic [CODE_W-1:0] CODE_HIGH = CODE_W'(2);
    localparam logic [CODE_W-1:0] CODE_FIX  = CODE_W'(3);

    ctl_state_e        state_q, state_n;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q, applied_q, fixcnt_q;
    logic              erased_q, done_q;
    logic [SEL_W-1:0]  sel_q;
    fix_status_e       verdict_q, status_q;
    logic              last, fixable, no_work;

    assign last    = (CNT_W'(sel_q) + CNT_W'(1)) == cnt_q;
    assign fixable = (code_q == CODE_HIGH) || (code_q == CODE_FIX);
    assign no_work = erased_q || (code_q == CODE_NONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_n = S_CLASSIFY;
            S_CLASSIFY: begin
                if (no_work || !fixable || cnt_q == '0) state_n = S_FINISH;
                else                                    state_n = S_FETCH;
            end
            S_FETCH: begin
                if (ent_hit)   state_n = S_MODIFY;
                else if (last) state_n = S_FINISH;
            end
            S_MODIFY:   state_n = last ? S_FINISH : S_FETCH;
            S_FINISH:   state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // job registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q    <= '0;
            cnt_q     <= '0;
            erased_q  <= 1'b0;
            sel_q     <= '0;
            applied_q <= '0;
            verdict_q <= FIX_CLEAN;
            status_q  <= FIX_CLEAN;
            fixcnt_q  <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (state_q == S_FINISH);
            unique case (state_q)
                S_IDLE: if (start) begin
                    code_q    <= code_i;
                    cnt_q     <= (cnt_i > MAX_CNT) ? MAX_CNT : cnt_i;
                    erased_q  <= erased_i;
                    sel_q     <= '0;
                    applied_q <= '0;
                end
                S_CLASSIFY: begin
                    if (no_work)      verdict_q <= FIX_CLEAN;
                    else if (fixable) verdict_q <= FIX_DONE;
                    else              verdict_q <= FIX_FAILED;
                end
                S_FETCH:  if (!ent_hit && !last) sel_q <= sel_q + SEL_W'(1);
                S_MODIFY: begin
                    applied_q <= applied_q + CNT_W'(1);
                    if (!last) sel_q <= sel_q + SEL_W'(1);
                end
                S_FINISH: begin
                    status_q <= verdict_q;
                    fixcnt_q <= applied_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        take_o    = (state_q == S_IDLE) && start;
        busy_o    = (state_q != S_IDLE);
        sel_o     = sel_q;
        eng_addr  = ent_idx;
        eng_we    = (state_q == S_MODIFY);
        eng_wdata = rd_data ^ ent_mask;
        done_o    = done_q;
        status_o  = status_q;
        fixcnt_o  = fixcnt_q;
    end

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(status_o));

    a_r4_fail_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == FIX_FAILED) |-> fixcnt_o == '0);

    a_r3_clean_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == FIX_CLEAN) |-> fixcnt_o == '0);

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fixcnt_o <= MAX_CNT);

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start) |=> $stable(code_q));

endmodule

// File: rtl/sector_fix_apply.sv
module sector_fix_apply
    import ecc_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = ecc_fix_pkg::SECTOR_BYTES,
    parameter int PARITY_BYTES = ecc_fix_pkg::PARITY_BYTES,
    parameter int MAX_ERRS     = ecc_fix_pkg::MAX_ERRS,
    parameter int LOC_W        = ecc_fix_pkg::LOC_W,
    parameter int MASK_W       = ecc_fix_pkg::MASK_W,
    parameter int CODE_W       = ecc_fix_pkg::CODE_W,
    parameter int WORD_W       = ecc_fix_pkg::WORD_W,
    parameter int LANE_SHIFT   = ecc_fix_pkg::LANE_SHIFT,
    localparam int IDX_W       = $clog2(SECTOR_BYTES),
    localparam int CNT_W       = $clog2(MAX_ERRS + 1),
    localparam int SEL_W       = $clog2(MAX_ERRS),
    localparam int NWORDS      = MAX_ERRS / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_we,
    input  logic [IDX_W-1:0]          host_addr,
    input  logic [MASK_W-1:0]         host_wdata,
    output logic [MASK_W-1:0]         host_rdata,
    input  logic                      start,
    input  logic [CODE_W-1:0]         corr_state,
    input  logic [CNT_W-1:0]          err_count,
    input  logic [WORD_W-1:0]         err_addr_lo,
    input  logic [WORD_W-1:0]         err_val_lo,
    input  logic [WORD_W-1:0]         err_addr_hi,
    input  logic [WORD_W-1:0]         err_val_hi,
    input  logic [PARITY_BYTES*8-1:0] stored_parity,
    output logic                      busy,
    output logic                      done,
    output logic [1:0]                fix_status,
    output logic [CNT_W-1:0]          fix_count
);

    logic [NWORDS-1:0][WORD_W-1:0] loc_live, mask_live, loc_q, mask_q;
    logic              erased, take, ent_hit, eng_we, ram_we;
    logic [SEL_W-1:0]  sel;
    logic [IDX_W-1:0]  ent_idx, eng_addr, ram_addr;
    logic [MASK_W-1:0] ent_mask, eng_wdata, ram_wdata, ram_rdata;

    assign loc_live  = {err_addr_hi, err_addr_lo};
    assign mask_live = {err_val_hi, err_val_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q  <= '0;
            mask_q <= '0;
        end else if (take) begin
            loc_q  <= loc_live;
            mask_q <= mask_live;
        end
    end

    parity_erase_check #(.NBYTES(PARITY_BYTES)) u_erase (
        .parity (stored_parity),
        .erased (erased)
    );

    err_entry_pick #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .MAX_ERRS     (MAX_ERRS),
        .LOC_W        (LOC_W),
        .MASK_W       (MASK_W),
        .WORD_W       (WORD_W),
        .LANE_SHIFT   (LANE_SHIFT)
    ) u_pick (
        .loc_words  (loc_q),
        .mask_words (mask_q),
        .sel        (sel),
        .hit        (ent_hit),
        .idx        (ent_idx),
        .mask       (ent_mask)
    );

    ecc_fix_ctrl #(
        .MAX_ERRS (MAX_ERRS),
        .CODE_W   (CODE_W),
        .MASK_W   (MASK_W),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .code_i    (corr_state),
        .cnt_i     (err_count),
        .erased_i  (erased),
        .ent_hit   (ent_hit),
        .ent_idx   (ent_idx),
        .ent_mask  (ent_mask),
        .rd_data   (ram_rdata),
        .take_o    (take),
        .sel_o     (sel),
        .eng_addr  (eng_addr),
        .eng_we    (eng_we),
        .eng_wdata (eng_wdata),
        .busy_o    (busy),
        .done_o    (done),
        .status_o  (fix_status),
        .fixcnt_o  (fix_count)
    );

    // buffer port: engine owns it for the whole job
    always_comb begin
        ram_addr  = busy ? eng_addr  : host_addr;
        ram_we    = busy ? eng_we    : host_we;
        ram_wdata = busy ? eng_wdata : host_wdata;
    end

    sector_ram #(.DEPTH(SECTOR_BYTES), .WIDTH(MASK_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign host_rdata = ram_rdata;

    a_r9_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ram_we) |-> eng_we);

endmodule

// File: tb/sector_fix_apply_test.sv
`timescale 1ns/1ps
module sector_fix_apply_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        start = 1'b0;
    logic [3:0]  corr_state = '0;
    logic [2:0]  err_count = '0;
    logic [31:0] err_addr_lo = '0, err_val_lo = '0, err_addr_hi = '0, err_val_hi = '0;
    logic [79:0] stored_parity = '0;
    logic        busy, done;
    logic [1:0]  fix_status;
    logic [2:0]  fix_count;

    always #4 clk = ~clk;

    sector_fix_apply uut (.*);

    localparam logic [79:0] NEAR_ERASED = {8'h7F, {72{1'b1}}};

    typedef struct packed {
        logic [3:0]  code;
        logic [2:0]  cnt;
        logic [31:0] aw0, vw0, aw1, vw1;
        logic        erased;
        logic [1:0]  st;
        logic [2:0]  n;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{4'd0, 3'd2, 32'h0014_000A, 32'h0011_0022, 32'h0, 32'h0, 1'b0, 2'b00, 3'd0},
        '{4'd3, 3'd1, 32'h0000_0107, 32'h0000_00A5, 32'h0, 32'h0, 1'b0, 2'b01, 3'd1},
        '{4'd3, 3'd4, 32'h0207_0008, 32'h0011_0022, 32'h0005_0100, 32'h0044_0033, 1'b0, 2'b01, 3'd3},
        '{4'd2, 3'd2, 32'h0064_0064, 32'h000F_00F0, 32'h0, 32'h0, 1'b0, 2'b01, 3'd2},
        '{4'd1, 3'd3, 32'h0050_0060, 32'h0001_0001, 32'h0070_0070, 32'h0001_0001, 1'b0, 2'b10, 3'd0},
        '{4'd3, 3'd4, 32'h0050_0060, 32'h0001_0001, 32'h0070_0080, 32'h0002_0002, 1'b1, 2'b00, 3'd0},
        '{4'd3, 3'd2, 32'h0300_0003, 32'h0077_0077, 32'h0, 32'h0, 1'b0, 2'b01, 3'd0},
        '{4'd9, 3'd2, 32'h0050_0060, 32'h0001_0001, 32'h0, 32'h0, 1'b0, 2'b10, 3'd0},
        '{4'd3, 3'd7, 32'hFC10_FC20, 32'hAB01_CD02, 32'hFC30_FC40, 32'hAB04_CD08, 1'b0, 2'b01, 3'd4}
    };

    int checks = 0, errs = 0;
    bit finished = 0;
    logic [7:0] mirror [512];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 9'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr = 9'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic verify_buffer(input string req);
        int bad = 0, first = -1;
        logic [7:0] d, fa, fe;
        fa = '0; fe = '0;
        for (int i = 0; i < 512; i++) begin
            host_read(i, d);
            if (d !== mirror[i]) begin
                bad++;
                if (first < 0) begin first = i; fa = d; fe = mirror[i]; end
            end
        end
        check(bad == 0, req, $sformatf("buffer byte %0d", first), fa, fe);
    endtask

    // expected effect computed from R2..R7, R11
    task automatic model(input vec_t v);
        int n, idx;
        logic [31:0] aw, vw;
        logic [9:0] a;
        logic [7:0] m;
        if (v.erased || !(v.code == 4'd2 || v.code == 4'd3)) return;
        n = (v.cnt > 3'd4) ? 4 : int'(v.cnt);
        for (int k = 0; k < n; k++) begin
            aw = (k < 2) ? v.aw0 : v.aw1;
            vw = (k < 2) ? v.vw0 : v.vw1;
            a  = (k % 2 == 1) ? aw[25:16] : aw[9:0];
            m  = (k % 2 == 1) ? vw[23:16] : vw[7:0];
            idx = 519 - int'(a);
            if (idx >= 0 && idx < 512) mirror[idx] = mirror[idx] ^ m;
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        corr_state = v.code; err_count = v.cnt;
        err_addr_lo = v.aw0; err_val_lo = v.vw0;
        err_addr_hi = v.aw1; err_val_hi = v.vw1;
        stored_parity = v.erased ? {80{1'b1}} : NEAR_ERASED;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int t = 0; t < 64; t++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        bit got;
        logic [7:0] d;
        vec_t busy_job, rogue;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fix_status == 2'b00, "R1", "status", fix_status, 0);
        check(fix_count == 3'd0, "R1", "count", fix_count, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check(busy == 1'b0, "R1", "busy", busy, 0);

        for (int i = 0; i < 512; i++) begin
            mirror[i] = 8'((i * 7 + 3) & 8'hFF);
            host_write(i, mirror[i]);
        end
        // R9 host write/read with one-cycle read latency
        host_write(5, 8'h3C); mirror[5] = 8'h3C;
        host_read(5, d);
        check(d == 8'h3C, "R9", "host readback", d, 8'h3C);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R11
        for (int v = 0; v < 9; v++) begin
            launch(VECS[v]);
            check(busy == 1'b1, "R8", $sformatf("vec %0d busy", v), busy, 1);
            wait_done(got);
            check(got, "R8", $sformatf("vec %0d done seen", v), got, 1);
            check(fix_status == VECS[v].st, "R5", $sformatf("vec %0d status", v),
                  fix_status, VECS[v].st);
            check(fix_count == VECS[v].n, "R7", $sformatf("vec %0d count", v),
                  fix_count, VECS[v].n);
            @(negedge clk);
            check(done == 1'b0, "R8", $sformatf("vec %0d done width", v), done, 0);
            model(VECS[v]);
            verify_buffer($sformatf("R6 vec %0d", v));
        end

        // R10 / R9: start and host write during a running job
        busy_job = '{4'd3, 3'd4, 32'h0080_0090, 32'h0010_0020,
                     32'h00A0_00B0, 32'h0040_0080, 1'b0, 2'b01, 3'd4};
        rogue    = '{4'd1, 3'd2, 32'h0050_0060, 32'h00FF_00FF,
                     32'h0, 32'h0, 1'b0, 2'b10, 3'd0};
        launch(busy_job);
        corr_state = rogue.code; err_addr_lo = rogue.aw0; err_val_lo = rogue.vw0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        host_we = 1'b1; host_addr = 9'd300; host_wdata = 8'h55;
        @(negedge clk);
        host_we = 1'b0;
        wait_done(got);
        check(got, "R10", "busy job done", got, 1);
        check(fix_status == 2'b01, "R10", "status kept", fix_status, 1);
        check(fix_count == 3'd4, "R10", "count kept", fix_count, 4);
        got = 0;
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        check(!got, "R10", "no second done", got, 0);
        check(fix_status == 2'b01, "R8", "status held", fix_status, 1);
        model(busy_job);
        verify_buffer("R9 write during busy dropped");

        finish_run();
    end

endmodule